// File: doc/BRIEF.md
# Multiprocessor-Capable Asynchronous Serial Channel

This block is one full-duplex asynchronous serial channel. It has a transmitter with a single holding register, a receiver with a single data register, and a baud prescaler shared by both. A small register port sets the character format and the divisor, and it reports status. Each character can carry seven or eight data bits, an optional even or odd parity bit, and one or two stop bits. In multiprocessor format, an extra address/data marker bit takes the place of the parity bit. With receive filtering on, the receiver drops every frame that is not marked as an address.

The channel can hold its output line low to send a line break. It detects a received break as an all-zero character. It holds back new transmit frames while the clear-to-send input is inactive. It latches loss of carrier when the carrier-detect input goes inactive. It drives a request-to-send output from a control bit.

Registers, selected by `addr`:
- `0` is control: bit0 eight-bit data, bit1 parity enable, bit2 odd parity, bit3 two stop bits, bit4 multiprocessor format, bit5 multiprocessor filter, bit6 send break, bit7 request-to-send.
- `1` is the baud divisor.
- `2` is data. A write loads the transmit holding register. A read returns the last accepted character.
- `3` is status.

Top module: `mpuart_chan`

## Requirements
- R1: After reset: `txd` is 1, `rts_n` is 1, control reads 0x00, the divisor reads 7, and status reads 0x02 (transmit holding register empty, every other flag 0).
- R2: Every transmitted bit cell lasts exactly 16*(divisor+1) clock cycles. The receiver oversamples at 16 ticks per bit and takes each bit near its centre.
- R3: A transmit frame is sent in this order: a 0 start bit, then the data bits LSB first (7 or 8, per control bit0), then the optional extra bit, then one or two 1 stop bits (per control bit3). The line idles at 1. Even parity (bit2=0) makes the count of ones over data plus parity even; odd parity makes it odd. Status bit1 is 1 while the transmit holding register is empty.
- R4: A received character sets status bit0 (data ready) and is read at the data register; in seven-bit mode, bit7 of the data reads 0. A read of the data register clears data ready.
- R5: Transmission and reception run at the same time without affecting each other.
- R6: With parity enabled and multiprocessor format off, a parity mismatch sets status bit4. The character is still delivered.
- R7: A 0 in the first stop bit position, when the frame is not all zeros, sets status bit3 (framing error). The character is still delivered.
- R8: A frame that is all zeros, including the stop position, sets status bit5 (break). It sets no framing error and no data ready. The receiver waits for the line to return to 1 before it looks for a new start bit.
- R9: While control bit6 is 1, `txd` is held at 0 and no frame starts. A pending character is sent after the bit clears.
- R10: In multiprocessor format (control bit4), the extra bit after the data is the marker bit, not parity. The transmitter sends the value last written to status-write bit7. The receiver stores the received marker in status bit7.
- R11: With multiprocessor format and filtering (control bit5) both on, a frame whose marker is 0 is discarded. It leaves data ready and the data register unchanged. A frame whose marker is 1 is delivered.
- R12: While `cts_n` is 1, no new transmit frame starts. The pending character is sent once `cts_n` returns to 0.
- R13: A 0-to-1 change on `dcd_n` sets status bit6. `rts_n` is the inverse of control bit7.
- R14: A character that is completed while data ready is still set sets status bit2 (overrun) and keeps the older data. Writing a 1 to any of status bits 2..6 clears that flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears data ready on a data read) |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| cts_n | input | 1 | Clear to send, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| rts_n | output | 1 | Request to send, active low |

## Verification
The transmit path is driven with several formats: eight data bits with no parity, seven data bits with even parity and two stops, eight data bits with odd parity, and multiprocessor format. Each captured line waveform is compared bit by bit, which separates bit order, length, parity sense and stop count. The receive path gets frames that are clean, frames with bad parity, frames with a dropped stop bit, a long all-zero break, and marker 0 and marker 1 frames under filtering. These show which flag each fault raises and which frames are delivered. Further tests hold the line with break, hold back transmission with clear-to-send, run both directions at once, and overrun the single data register.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;

    localparam int OVS      = 16;   // oversampling ticks per bit cell
    localparam int TX_MAXB  = 12;   // start + 8 data + extra + 2 stops
    localparam int RX_MAXB  = 10;   // 8 data + extra + first stop

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_DIV  = 2'd1,
        A_DATA = 2'd2,
        A_STAT = 2'd3
    } reg_addr_e;

    // character format, low five control bits
    typedef struct packed {
        logic mp_en;
        logic stop2;
        logic par_odd;
        logic par_en;
        logic len8;
    } fmt_t;

    typedef struct packed {
        logic rts;
        logic brk;
        logic mp_filt;
        fmt_t fmt;
    } ctrl_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_BITS,
        RX_FIN,
        RX_WAITHI
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       mpb;
        logic       par_err;
        logic       frm_err;
        logic       brk;
    } rx_result_t;

    // parity bit that gives the requested sense over the data bits
    function automatic logic parity_bit(input logic [7:0] d, input logic len8,
                                        input logic odd);
        logic [7:0] m;
        m = len8 ? d : {1'b0, d[6:0]};
        return (^m) ^ odd;
    endfunction

endpackage

// File: rtl/mpuart_baud.sv
module mpuart_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= div) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/mpuart_tx.sv
module mpuart_tx
    import mpuart_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  fmt_t       fmt,
    input  logic       brk,
    input  logic       hold_valid,
    input  logic [7:0] hold_data,
    input  logic       hold_mpb,
    input  logic       cts_ok,
    output logic       take,
    output logic       busy,
    output logic       txd
);
    localparam int CW = $clog2(OVS);

    logic [TX_MAXB-1:0] frame, shreg;
    logic [3:0]         nbits, bits_left;
    logic [CW-1:0]      tcnt;
    logic               extra, xval;

    always_comb begin
        extra = fmt.mp_en | fmt.par_en;
        xval  = fmt.mp_en ? hold_mpb
                          : parity_bit(hold_data, fmt.len8, fmt.par_odd);
        frame      = '1;
        frame[0]   = 1'b0;
        frame[8:1] = hold_data;
        if (!fmt.len8) frame[8] = 1'b1;
        if (extra) begin
            if (fmt.len8) frame[9] = xval;
            else          frame[8] = xval;
        end
        nbits = 4'd9 + {3'b0, fmt.len8} + {3'b0, extra} + {3'b0, fmt.stop2};
        take  = !busy && tick && hold_valid && cts_ok && !brk;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            shreg     <= '1;
            bits_left <= '0;
            tcnt      <= '0;
            txd       <= 1'b1;
        end else begin
            if (take) begin
                busy      <= 1'b1;
                shreg     <= frame;
                bits_left <= nbits;
                tcnt      <= '0;
            end else if (busy && tick) begin
                if (tcnt == CW'(OVS - 1)) begin
                    tcnt      <= '0;
                    shreg     <= {1'b1, shreg[TX_MAXB-1:1]};
                    bits_left <= bits_left - 1'b1;
                    if (bits_left == 4'd1) busy <= 1'b0;
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
            txd <= brk ? 1'b0 : (busy ? shreg[0] : 1'b1);
        end
    end
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
    import mpuart_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       len8,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       mp_en,
    input  logic       rxd_s,
    output logic       done,
    output rx_result_t res
);
    localparam int CW = $clog2(OVS);

    rx_state_e          st;
    logic [CW-1:0]      tcnt;
    logic [3:0]         idx, nrx, sidx, xidx;
    logic [RX_MAXB-1:0] rbits, mask;
    logic               extra, stop_v, x_v, allzero;
    logic [7:0]         dval;

    always_comb begin
        extra   = mp_en | par_en;
        xidx    = 4'd7 + {3'b0, len8};
        sidx    = xidx + {3'b0, extra};
        nrx     = sidx + 4'd1;
        mask    = RX_MAXB'((11'h1 << nrx) - 11'h1);
        allzero = (rbits & mask) == '0;
        stop_v  = rbits[sidx];
        x_v     = rbits[xidx];
        dval    = len8 ? rbits[7:0] : {1'b0, rbits[6:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= RX_IDLE;
            tcnt  <= '0;
            idx   <= '0;
            rbits <= '0;
            done  <= 1'b0;
            res   <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                RX_IDLE: if (tick && !rxd_s) begin
                    st   <= RX_START;
                    tcnt <= '0;
                end
                RX_START: if (tick) begin
                    if (tcnt == CW'(OVS / 2 - 1)) begin
                        tcnt  <= '0;
                        idx   <= '0;
                        rbits <= '0;
                        st    <= rxd_s ? RX_IDLE : RX_BITS;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                RX_BITS: if (tick) begin
                    if (tcnt == CW'(OVS - 1)) begin
                        tcnt       <= '0;
                        rbits[idx] <= rxd_s;
                        idx        <= idx + 1'b1;
                        if (idx == sidx) st <= RX_FIN;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                RX_FIN: begin
                    done        <= 1'b1;
                    res.data    <= dval;
                    res.mpb     <= mp_en & x_v;
                    res.brk     <= allzero;
                    res.frm_err <= !stop_v && !allzero;
                    res.par_err <= !mp_en && par_en && !allzero &&
                                   (x_v != parity_bit(dval, len8, par_odd));
                    st          <= stop_v ? RX_IDLE : RX_WAITHI;
                end
                RX_WAITHI: if (rxd_s) st <= RX_IDLE;
                default: st <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mpuart_chan.sv
module mpuart_chan
    import mpuart_pkg::*;
#(
    parameter int              DIV_W    = 8,
    parameter logic [DIV_W-1:0] DIV_INIT = DIV_W'(7)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       txd,
    input  logic       rxd,
    input  logic       cts_n,
    input  logic       dcd_n,
    output logic       rts_n
);
    ctrl_t            ctrl;
    logic [DIV_W-1:0] div;
    logic [7:0]       hold_data, rx_data;
    logic             hold_valid, tx_mpb, rx_mpb, rx_ready;
    logic             overrun, frm_flag, par_flag, brk_flag, dcd_lost;
    logic [1:0]       rxd_q, cts_q, dcd_q;
    logic             dcd_prev, tick, take, tx_busy, rx_done, filt_on;
    rx_result_t       rx_res;

    wire wr_ctrl = wr_en && addr == A_CTRL;
    wire wr_div  = wr_en && addr == A_DIV;
    wire wr_data = wr_en && addr == A_DATA;
    wire wr_stat = wr_en && addr == A_STAT;
    wire rd_data = rd_en && addr == A_DATA;

    assign filt_on = ctrl.fmt.mp_en && ctrl.mp_filt;
    assign rts_n   = !ctrl.rts;

    mpuart_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst(rst), .div(div), .tick(tick)
    );

    mpuart_tx u_tx (
        .clk(clk), .rst(rst), .tick(tick), .fmt(ctrl.fmt), .brk(ctrl.brk),
        .hold_valid(hold_valid), .hold_data(hold_data), .hold_mpb(tx_mpb),
        .cts_ok(!cts_q[1]), .take(take), .busy(tx_busy), .txd(txd)
    );

    mpuart_rx u_rx (
        .clk(clk), .rst(rst), .tick(tick), .len8(ctrl.fmt.len8),
        .par_en(ctrl.fmt.par_en), .par_odd(ctrl.fmt.par_odd),
        .mp_en(ctrl.fmt.mp_en), .rxd_s(rxd_q[1]), .done(rx_done), .res(rx_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rxd_q    <= 2'b11;
            cts_q    <= 2'b11;
            dcd_q    <= 2'b11;
            dcd_prev <= 1'b1;
        end else begin
            rxd_q    <= {rxd_q[0], rxd};
            cts_q    <= {cts_q[0], cts_n};
            dcd_q    <= {dcd_q[0], dcd_n};
            dcd_prev <= dcd_q[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl       <= '0;
            div        <= DIV_INIT;
            hold_data  <= '0;
            hold_valid <= 1'b0;
            tx_mpb     <= 1'b0;
            rx_data    <= '0;
            rx_mpb     <= 1'b0;
            rx_ready   <= 1'b0;
            overrun    <= 1'b0;
            frm_flag   <= 1'b0;
            par_flag   <= 1'b0;
            brk_flag   <= 1'b0;
            dcd_lost   <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl <= ctrl_t'(wdata);
            if (wr_div)  div  <= DIV_W'(wdata);
            if (wr_data) begin
                hold_data  <= wdata;
                hold_valid <= 1'b1;
            end else if (take) begin
                hold_valid <= 1'b0;
            end
            if (wr_stat) begin
                tx_mpb <= wdata[7];
                if (wdata[2]) overrun  <= 1'b0;
                if (wdata[3]) frm_flag <= 1'b0;
                if (wdata[4]) par_flag <= 1'b0;
                if (wdata[5]) brk_flag <= 1'b0;
                if (wdata[6]) dcd_lost <= 1'b0;
            end
            if (rd_data) rx_ready <= 1'b0;
            if (dcd_q[1] && !dcd_prev) dcd_lost <= 1'b1;
            if (rx_done) begin
                if (rx_res.brk) begin
                    brk_flag <= 1'b1;
                end else if (filt_on && !rx_res.mpb) begin
                    // unmarked frame under filtering: dropped
                end else if (rx_ready && !rd_data) begin
                    overrun <= 1'b1;
                end else begin
                    rx_data  <= rx_res.data;
                    rx_mpb   <= rx_res.mpb;
                    rx_ready <= 1'b1;
                    if (rx_res.frm_err) frm_flag <= 1'b1;
                    if (rx_res.par_err) par_flag <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        unique case (reg_addr_e'(addr))
            A_CTRL:  rdata = ctrl;
            A_DIV:   rdata = 8'(div);
            A_DATA:  rdata = rx_data;
            default: rdata = {rx_mpb, dcd_lost, brk_flag, par_flag, frm_flag,
                              overrun, !hold_valid, rx_ready};
        endcase
    end
endmodule

// File: rtl/mpuart_chan_chk.sv
module mpuart_chan_chk
    import mpuart_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       txd,
    input logic       brk,
    input logic       tx_busy,
    input logic       cts_s,
    input logic       rx_done,
    input rx_result_t rx_res,
    input logic       filt_on,
    input logic       rd_en,
    input logic       wr_en,
    input logic [1:0] addr,
    input logic       rx_ready,
    input logic [7:0] rx_data,
    input logic       brk_flag,
    input logic       frm_flag,
    input logic       dcd_s,
    input logic       dcd_prev,
    input logic       dcd_lost
);
    AST_BREAK_HOLDS_LINE: assert property (@(posedge clk) disable iff (rst)
        brk |=> !txd); // R9

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!tx_busy && !brk && $past(!tx_busy && !brk)) |-> txd); // R3

    AST_CTS_BLOCKS_START: assert property (@(posedge clk) disable iff (rst)
        (!tx_busy && cts_s) |=> !tx_busy); // R12

    AST_FILTER_DROPS: assert property (@(posedge clk) disable iff (rst)
        (rx_done && filt_on && !rx_res.mpb && !rx_res.brk &&
         !(rd_en && addr == 2'd2))
        |=> ($stable(rx_ready) && $stable(rx_data))); // R11

    AST_BREAK_NOT_FRAMING: assert property (@(posedge clk) disable iff (rst)
        (rx_done && rx_res.brk && !(wr_en && addr == 2'd3))
        |=> (brk_flag && $stable(frm_flag) && $stable(rx_ready))); // R8

    AST_DCD_LATCH: assert property (@(posedge clk) disable iff (rst)
        (dcd_s && !dcd_prev) |=> dcd_lost); // R13
endmodule

bind mpuart_chan mpuart_chan_chk u_chk (
    .clk(clk), .rst(rst), .txd(txd), .brk(ctrl.brk), .tx_busy(tx_busy),
    .cts_s(cts_q[1]), .rx_done(rx_done), .rx_res(rx_res), .filt_on(filt_on),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .rx_ready(rx_ready),
    .rx_data(rx_data), .brk_flag(brk_flag), .frm_flag(frm_flag),
    .dcd_s(dcd_q[1]), .dcd_prev(dcd_prev), .dcd_lost(dcd_lost)
);

// File: tb/mpuart_chan_test.sv
`timescale 1ns/1ps
module mpuart_chan_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       txd;
    logic       rxd = 1'b1, cts_n = 1'b0, dcd_n = 1'b0;
    logic       rts_n;

    int n_chk = 0, n_bad = 0;
    int bitc = 32;

    always #2.5 clk = ~clk;

    mpuart_chan uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .txd(txd), .rxd(rxd), .cts_n(cts_n),
        .dcd_n(dcd_n), .rts_n(rts_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // expected line frame, built from the format rules
    function automatic logic [11:0] mk(input logic [7:0] d, input logic [7:0] c,
                                      input logic mpb, output int n);
        logic [11:0] f;
        int nd, p;
        logic x;
        f = '1; f[0] = 1'b0;
        nd = c[0] ? 8 : 7;
        for (int i = 0; i < nd; i++) f[1+i] = d[i];
        p = 1 + nd;
        if (c[4] || c[1]) begin
            x = 1'b0;
            for (int i = 0; i < nd; i++) x = x ^ d[i];
            f[p] = c[4] ? mpb : (x ^ c[2]);
            p++;
        end
        n = p + (c[3] ? 2 : 1);
        return f;
    endfunction

    task automatic drive_rx(input logic [11:0] f, input int n);
        for (int i = 0; i < n; i++) begin
            rxd = f[i];
            repeat (bitc) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic cap_tx(input int n, output logic [11:0] got);
        int to;
        got = '1;
        to = 0;
        @(negedge clk);
        while (txd !== 1'b1 && to < 20000) begin @(negedge clk); to++; end
        while (txd !== 1'b0 && to < 20000) begin @(negedge clk); to++; end
        repeat (bitc / 2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            got[i] = txd;
            if (i < n - 1) repeat (bitc) @(negedge clk);
        end
        repeat (bitc) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R1 txd idle", txd, 1'b1);
        chk("R1 rts_n", rts_n, 1'b1);
        rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
        rd(2'd1, v); chk("R1 divisor", v, 8'd7);
        rd(2'd3, v); chk("R1 status", v, 8'h02);
    endtask

    task automatic t_baud;
        int cnt;
        wr(2'd0, 8'h01);
        wr(2'd1, 8'd2);
        wr(2'd2, 8'h55);
        cnt = 0;
        while (txd !== 1'b0 && cnt < 5000) begin @(negedge clk); cnt++; end
        cnt = 0;
        while (txd === 1'b0 && cnt < 5000) begin @(negedge clk); cnt++; end
        chk("R2 start cell length div=2", cnt, 48);
        repeat (12 * 48) @(negedge clk);
        wr(2'd1, 8'd1);
        bitc = 32;
    endtask

    task automatic t_tx_one(input logic [7:0] c, input logic [7:0] d, input string tag);
        logic [11:0] e, g;
        logic [7:0] v;
        int n;
        wr(2'd0, c);
        e = mk(d, c, 1'b0, n);
        wr(2'd2, d);
        cap_tx(n, g);
        chk(tag, g, e);
        chk("R3 line back to idle", txd, 1'b1);
        rd(2'd3, v); chk("R3 holding empty", v[1], 1'b1);
    endtask

    task automatic t_rx_one(input logic [7:0] c, input logic [7:0] d, input string tag);
        logic [11:0] f;
        logic [7:0] v, ed;
        int n;
        wr(2'd0, c);
        f = mk(d, c, 1'b0, n);
        drive_rx(f, n);
        ed = c[0] ? d : {1'b0, d[6:0]};
        rd(2'd3, v); chk({tag, " ready"}, v[0], 1'b1);
        rd(2'd2, v); chk({tag, " data"}, v, ed);
        rd(2'd3, v); chk("R4 ready cleared by read", v[0], 1'b0);
    endtask

    task automatic t_parity;
        logic [11:0] f;
        logic [7:0] v;
        int n;
        wr(2'd0, 8'h03);
        f = mk(8'h5B, 8'h03, 1'b0, n);
        f[9] = ~f[9];
        drive_rx(f, n);
        rd(2'd3, v); chk("R6 parity flag", v[4], 1'b1);
        rd(2'd2, v); chk("R6 data delivered", v, 8'h5B);
        wr(2'd3, 8'h7C);
        rd(2'd3, v); chk("R14 flags cleared", v & 8'h7C, 8'h00);
    endtask

    task automatic t_framing;
        logic [11:0] f;
        logic [7:0] v;
        int n;
        wr(2'd0, 8'h01);
        f = mk(8'h81, 8'h01, 1'b0, n);
        f[n-1] = 1'b0;
        drive_rx(f, n);
        rd(2'd3, v); chk("R7 framing flag", v[3], 1'b1);
        chk("R7 ready", v[0], 1'b1);
        rd(2'd2, v); chk("R7 data", v, 8'h81);
        wr(2'd3, 8'h7C);
    endtask

    task automatic t_break_rx;
        logic [7:0] v;
        rxd = 1'b0;
        repeat (14 * bitc) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * bitc) @(negedge clk);
        rd(2'd3, v);
        chk("R8 break flag", v[5], 1'b1);
        chk("R8 no framing", v[3], 1'b0);
        chk("R8 no ready", v[0], 1'b0);
        wr(2'd3, 8'h7C);
        t_rx_one(8'h01, 8'hC3, "R8 receive after break");
    endtask

    task automatic t_send_break;
        logic [11:0] e, g;
        logic [7:0] v;
        int n, lows;
        wr(2'd0, 8'h41);
        wr(2'd2, 8'h5A);
        lows = 0;
        for (int i = 0; i < 6; i++) begin
            repeat (bitc / 2) @(negedge clk);
            if (txd === 1'b0) lows++;
        end
        chk("R9 line held low", lows, 6);
        rd(2'd3, v); chk("R9 no frame started", v[1], 1'b0);
        e = mk(8'h5A, 8'h01, 1'b0, n);
        fork
            wr(2'd0, 8'h01);
            cap_tx(n, g);
        join
        chk("R9 pending frame after break", g, e);
    endtask

    task automatic t_mp;
        logic [11:0] e, g, f;
        logic [7:0] v;
        int n;
        wr(2'd0, 8'h11);
        wr(2'd3, 8'h80);
        e = mk(8'h12, 8'h11, 1'b1, n);
        wr(2'd2, 8'h12);
        cap_tx(n, g);
        chk("R10 marked tx frame", g, e);
        f = mk(8'h44, 8'h11, 1'b1, n);
        drive_rx(f, n);
        rd(2'd3, v); chk("R10 rx marker", v[7], 1'b1);
        chk("R10 ready", v[0], 1'b1);
        rd(2'd2, v); chk("R10 rx data", v, 8'h44);
        wr(2'd3, 8'h00);
    endtask

    task automatic t_filter;
        logic [11:0] f;
        logic [7:0] v;
        int n;
        wr(2'd0, 8'h31);
        f = mk(8'h99, 8'h31, 1'b0, n);
        drive_rx(f, n);
        rd(2'd3, v); chk("R11 unmarked dropped", v[0], 1'b0);
        rd(2'd2, v); chk("R11 data unchanged", v, 8'h44);
        f = mk(8'h21, 8'h31, 1'b1, n);
        drive_rx(f, n);
        rd(2'd3, v); chk("R11 marked accepted", v[0], 1'b1);
        rd(2'd2, v); chk("R11 marked data", v, 8'h21);
    endtask

    task automatic t_duplex;
        logic [11:0] e, g, f;
        logic [7:0] v;
        int n, m;
        wr(2'd0, 8'h01);
        e = mk(8'h6B, 8'h01, 1'b0, n);
        f = mk(8'hD2, 8'h01, 1'b0, m);
        fork
            wr(2'd2, 8'h6B);
            cap_tx(n, g);
            drive_rx(f, m);
        join
        chk("R5 tx during rx", g, e);
        rd(2'd2, v); chk("R5 rx during tx", v, 8'hD2);
    endtask

    task automatic t_cts;
        logic [11:0] e, g;
        logic [7:0] v;
        int highs, n;
        wr(2'd0, 8'h01);
        cts_n = 1'b1;
        repeat (4) @(negedge clk);
        wr(2'd2, 8'h3E);
        highs = 0;
        for (int i = 0; i < 6; i++) begin
            repeat (bitc / 2) @(negedge clk);
            if (txd === 1'b1) highs++;
        end
        chk("R12 no start while cts inactive", highs, 6);
        rd(2'd3, v); chk("R12 still pending", v[1], 1'b0);
        e = mk(8'h3E, 8'h01, 1'b0, n);
        cts_n = 1'b0;
        cap_tx(n, g);
        chk("R12 frame after cts", g, e);
    endtask

    task automatic t_modem;
        logic [7:0] v;
        rd(2'd3, v); chk("R13 no carrier loss yet", v[6], 1'b0);
        dcd_n = 1'b1;
        repeat (6) @(negedge clk);
        rd(2'd3, v); chk("R13 carrier loss latched", v[6], 1'b1);
        wr(2'd3, 8'h40);
        rd(2'd3, v); chk("R14 carrier flag cleared", v[6], 1'b0);
        wr(2'd0, 8'h81);
        @(negedge clk);
        chk("R13 rts asserted", rts_n, 1'b0);
        wr(2'd0, 8'h01);
        @(negedge clk);
        chk("R13 rts released", rts_n, 1'b1);
    endtask

    task automatic t_overrun;
        logic [11:0] f;
        logic [7:0] v;
        int n;
        wr(2'd0, 8'h01);
        f = mk(8'hA1, 8'h01, 1'b0, n);
        drive_rx(f, n);
        f = mk(8'hB2, 8'h01, 1'b0, n);
        drive_rx(f, n);
        rd(2'd3, v); chk("R14 overrun flag", v[2], 1'b1);
        rd(2'd2, v); chk("R14 older data kept", v, 8'hA1);
        wr(2'd3, 8'h04);
        rd(2'd3, v); chk("R14 overrun cleared", v[2], 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_baud();
        t_tx_one(8'h01, 8'hA5, "R3 8N1 frame");
        t_tx_one(8'h0A, 8'h53, "R3 7E2 frame");
        t_tx_one(8'h07, 8'h0F, "R3 8O1 frame");
        t_rx_one(8'h01, 8'h3C, "R4 8N1");
        t_rx_one(8'h0A, 8'hD3, "R4 7E2");
        t_parity();
        t_framing();
        t_break_rx();
        t_send_break();
        t_mp();
        t_filter();
        t_duplex();
        t_cts();
        t_modem();
        t_overrun();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule